// File: doc/BRIEF.md
# Cache Line Atomic Swap Unit

This block holds one cache line in a local buffer and performs read-modify-write atomics on a 4-byte or 8-byte word inside it. It supports two kinds of request. An unconditional exchange always stores the new operand. A compare-gated exchange stores the new operand only when the current bytes equal a compare operand carried with the request. Either way, the bytes that were at the target before the operation are handed back to the requester.

Work runs in two cycles. In the first, the request is captured and the unit raises its busy flag. In the second, the addressed bytes are read and checked, the line is updated in place if the store goes ahead, and a registered response comes out together with a copy of the whole updated line and a byte mask of what changed. A full-line fill port loads the buffer while the unit is idle. Requests that name an illegal size or a misaligned offset are answered with an error flag and leave the line as it was.

Top module: `atomic_line_unit`

## Requirements
- R1: After reset, busy, rsp_valid and wb_valid are 0, and every byte of the line buffer reads as zero.
- R2: When busy is 0, fill_valid high for one cycle loads fill_data into the line; byte k of the line is bits [8k+7:8k]. While busy is 1, fill_valid is ignored and the line is unchanged.
- R3: A request is accepted when req_valid is 1, busy is 0 and fill_valid is 0. busy is 1 for exactly the one cycle after acceptance. rsp_valid pulses for one cycle on the edge after that. A request presented while busy is 1 is ignored and produces no response.
- R4: req_op 0 is an unconditional exchange. With a legal size and offset it always writes the low req_size bytes of req_new into the line, little-endian, starting at byte req_off, and returns the previous bytes in rsp_old.
- R5: req_op 1 is a compare-gated exchange. With req_size 8, all 64 bits of req_cmp are compared with the current 8 bytes; the line is written only on equality. The previous bytes are returned in either case.
- R6: With req_size 4 and req_op 1, only req_cmp[31:0] takes part in the comparison, and only req_new[31:0] is stored. req_cmp[63:32] and req_new[63:32] have no effect.
- R7: req_size is a byte count. Any value other than 4 or 8 sets rsp_err, leaves the line unchanged and returns rsp_old = 0. This holds for both op codes.
- R8: A req_off that is not a multiple of a legal req_size sets rsp_err, leaves the line unchanged and returns rsp_old = 0.
- R9: When the line is written, wb_valid pulses together with rsp_valid. wb_data then carries the whole updated line and wb_mask has bit k set exactly for the bytes that were written. When nothing is written, wb_valid stays 0.
- R10: For a 4-byte operation, rsp_old[63:32] is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Load the whole line buffer |
| fill_data | input | LINE_BYTES*8 | Line contents to load |
| req_valid | input | 1 | Atomic request strobe |
| req_op | input | 1 | 0 unconditional exchange, 1 compare-gated exchange |
| req_size | input | 4 | Operand size in bytes (4 or 8 legal) |
| req_off | input | OFF_W | Byte offset of the operand within the line |
| req_new | input | 64 | Value to store |
| req_cmp | input | 64 | Compare operand for the gated exchange |
| busy | output | 1 | Unit is between capture and completion |
| rsp_valid | output | 1 | Response strobe |
| rsp_old | output | 64 | Bytes at the target before the operation |
| rsp_err | output | 1 | Illegal size or misaligned offset |
| wb_valid | output | 1 | Line was modified this operation |
| wb_data | output | LINE_BYTES*8 | Updated line contents |
| wb_mask | output | LINE_BYTES | Bytes that were written |

## Verification
The bench targets a gated exchange whose compare operand differs only in the upper half while the size is 4. A design that compared all 64 bits would then refuse a store it should make. It checks 8-byte operations at the last legal offset of the line, where a wrong byte index would corrupt a neighbour or wrap around. It issues sizes of 0 and 5 and offsets off the operand boundary; a design that skipped the legality check would write the line or return stale data. It also drives new requests and fills while the unit is busy, and then reads the line back non-destructively, to catch a capture path that lets a second operation or a fill slip into the completion cycle.

// File: rtl/atomic_line_pkg.sv
package atomic_line_pkg;

  localparam int WORD_BYTES = 8;
  localparam int WORD_BITS  = WORD_BYTES * 8;

  typedef enum logic {
    OP_XCHG  = 1'b0,
    OP_CXCHG = 1'b1
  } atom_op_e;

  // A size is legal when it is one of the two supported byte counts.
  function automatic logic size_ok(input logic [3:0] sz);
    return (sz == 4'd4) || (sz == 4'd8);
  endfunction

  // Number of bytes touched for a legal size.
  function automatic int nbytes(input logic [3:0] sz);
    return (sz == 4'd8) ? 8 : 4;
  endfunction

endpackage

// File: rtl/atomic_line_check.sv
module atomic_line_check
  import atomic_line_pkg::*;
#(
  parameter int OFF_W = 5
) (
  input  logic [3:0]       size,
  input  logic [OFF_W-1:0] off,
  output logic             bad_size,
  output logic             bad_align
);
  // Low bits of the offset that must be zero for the given size.
  function automatic logic misaligned(input logic [3:0] sz, input logic [OFF_W-1:0] o);
    logic [OFF_W-1:0] m;
    m = (sz == 4'd8) ? OFF_W'(7) : OFF_W'(3);
    return (o & m) != '0;
  endfunction

  always_comb begin
    bad_size  = !size_ok(size);
    bad_align = size_ok(size) && misaligned(size, off);
  end
endmodule

// File: rtl/atomic_line_exec.sv
module atomic_line_exec
  import atomic_line_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic [LINE_BITS-1:0]  line,
  input  atom_op_e              op,
  input  logic [3:0]            size,
  input  logic [OFF_W-1:0]      off,
  input  logic [WORD_BITS-1:0]  new_val,
  input  logic [WORD_BITS-1:0]  cmp_val,
  output logic [WORD_BITS-1:0]  old_val,
  output logic                  cmp_hit,
  output logic                  want_write,
  output logic [LINE_BITS-1:0]  merged,
  output logic [LINE_BYTES-1:0] touched
);
  // Gather the addressed bytes, little-endian, zero above the operand.
  function automatic logic [WORD_BITS-1:0] pick(
      input logic [LINE_BITS-1:0] ln, input logic [OFF_W-1:0] o, input int n);
    logic [WORD_BITS-1:0] r;
    logic [OFF_W-1:0]     ix;
    r = '0;
    for (int i = 0; i < WORD_BYTES; i++) begin
      ix = o + OFF_W'(i);
      if (i < n) r[i*8 +: 8] = ln[int'(ix)*8 +: 8];
    end
    return r;
  endfunction

  // Lay the low n bytes of v over the line at offset o.
  function automatic logic [LINE_BITS-1:0] lay(
      input logic [LINE_BITS-1:0] ln, input logic [OFF_W-1:0] o,
      input int n, input logic [WORD_BITS-1:0] v);
    logic [LINE_BITS-1:0] r;
    logic [OFF_W-1:0]     ix;
    r = ln;
    for (int i = 0; i < WORD_BYTES; i++) begin
      ix = o + OFF_W'(i);
      if (i < n) r[int'(ix)*8 +: 8] = v[i*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [LINE_BYTES-1:0] span(input logic [OFF_W-1:0] o, input int n);
    logic [LINE_BYTES-1:0] r;
    logic [OFF_W-1:0]      ix;
    r = '0;
    for (int i = 0; i < WORD_BYTES; i++) begin
      ix = o + OFF_W'(i);
      if (i < n) r[int'(ix)] = 1'b1;
    end
    return r;
  endfunction

  int nb;
  always_comb begin
    nb      = nbytes(size);
    old_val = pick(line, off, nb);
    cmp_hit = (nb == 8) ? (cmp_val == old_val)
                        : (cmp_val[31:0] == old_val[31:0]);
    want_write = (op == OP_XCHG) || cmp_hit;
    merged  = lay(line, off, nb, new_val);
    touched = span(off, nb);
  end
endmodule

// File: rtl/atomic_line_buf.sv
module atomic_line_buf #(
  parameter int LINE_BYTES = 32,
  localparam int LINE_BITS = LINE_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_en,
  input  logic [LINE_BITS-1:0] fill_data,
  input  logic                 wr_en,
  input  logic [LINE_BITS-1:0] wr_data,
  output logic [LINE_BITS-1:0] line_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (wr_en)   line_q <= wr_data;
    else if (fill_en) line_q <= fill_data;
  end

  // R2: a fill and an atomic store never land in the same cycle
  a_r2_fill_store_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && wr_en));
endmodule

// File: rtl/atomic_line_unit.sv
module atomic_line_unit
  import atomic_line_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_valid,
  input  logic [LINE_BITS-1:0]  fill_data,
  input  logic                  req_valid,
  input  logic                  req_op,
  input  logic [3:0]            req_size,
  input  logic [OFF_W-1:0]      req_off,
  input  logic [63:0]           req_new,
  input  logic [63:0]           req_cmp,
  output logic                  busy,
  output logic                  rsp_valid,
  output logic [63:0]           rsp_old,
  output logic                  rsp_err,
  output logic                  wb_valid,
  output logic [LINE_BITS-1:0]  wb_data,
  output logic [LINE_BYTES-1:0] wb_mask
);
  // Named internal events
  logic accept, fill_take, stage_err, commit;
  logic bad_size, bad_align;

  atom_op_e               s_op;
  logic [3:0]             s_size;
  logic [OFF_W-1:0]       s_off;
  logic [WORD_BITS-1:0]   s_new, s_cmp;
  logic                   busy_q;

  logic [LINE_BITS-1:0]   line_q, merged;
  logic [LINE_BYTES-1:0]  touched;
  logic [WORD_BITS-1:0]   old_val;
  logic                   cmp_hit, want_write;

  assign accept    = req_valid && !busy_q && !fill_valid;
  assign fill_take = fill_valid && !busy_q;
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      s_op   <= OP_XCHG;
      s_size <= '0;
      s_off  <= '0;
      s_new  <= '0;
      s_cmp  <= '0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        s_op   <= atom_op_e'(req_op);
        s_size <= req_size;
        s_off  <= req_off;
        s_new  <= req_new;
        s_cmp  <= req_cmp;
      end
    end
  end

  atomic_line_check #(.OFF_W(OFF_W)) u_check (
    .size(s_size), .off(s_off), .bad_size(bad_size), .bad_align(bad_align)
  );

  atomic_line_exec #(.LINE_BYTES(LINE_BYTES)) u_exec (
    .line(line_q), .op(s_op), .size(s_size), .off(s_off),
    .new_val(s_new), .cmp_val(s_cmp), .old_val(old_val), .cmp_hit(cmp_hit),
    .want_write(want_write), .merged(merged), .touched(touched)
  );

  assign stage_err = bad_size || bad_align;
  assign commit    = busy_q && !stage_err && want_write;

  atomic_line_buf #(.LINE_BYTES(LINE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_take), .fill_data(fill_data),
    .wr_en(commit), .wr_data(merged), .line_q(line_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_old   <= '0;
      rsp_err   <= 1'b0;
      wb_valid  <= 1'b0;
      wb_data   <= '0;
      wb_mask   <= '0;
    end else begin
      rsp_valid <= busy_q;
      rsp_old   <= (busy_q && !stage_err) ? old_val : '0;
      rsp_err   <= busy_q && stage_err;
      wb_valid  <= commit;
      wb_data   <= merged;
      wb_mask   <= commit ? touched : '0;
    end
  end

  // R3: busy lasts one cycle and is followed by the response
  a_r3_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);
  a_r3_rsp_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> rsp_valid);
  a_r3_capture_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q);
  // R7/R8: a rejected request never modifies the line
  a_r7_err_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !wb_valid);
  // R9: write-back only with a response, and it covers one operand
  a_r9_wb_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> rsp_valid);
  a_r9_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ($countones(wb_mask) == 4 || $countones(wb_mask) == 8));
  // R4: a legal unconditional exchange always stores
  a_r4_xchg_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !stage_err && s_op == OP_XCHG) |=> wb_valid);
  // R10: a 4-byte result has a zero upper half
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && s_size == 4'd4) |=> (rsp_old[63:32] == 32'h0));
endmodule

// File: tb/tb_atomic_line_unit.sv
`timescale 1ns/1ps
module tb_atomic_line_unit;
  localparam int LB = 32;
  localparam int LW = LB * 8;

  logic          clk = 0, rst_n = 0;
  logic          fill_valid = 0, req_valid = 0, req_op = 0;
  logic [LW-1:0] fill_data = '0;
  logic [3:0]    req_size = 0;
  logic [4:0]    req_off = 0;
  logic [63:0]   req_new = 0, req_cmp = 0;
  logic          busy, rsp_valid, rsp_err, wb_valid;
  logic [63:0]   rsp_old;
  logic [LW-1:0] wb_data;
  logic [LB-1:0] wb_mask;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] mb [LB];

  always #5 clk = ~clk;

  atomic_line_unit #(.LINE_BYTES(LB)) dut (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_data(fill_data),
    .req_valid(req_valid), .req_op(req_op), .req_size(req_size), .req_off(req_off),
    .req_new(req_new), .req_cmp(req_cmp), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_old(rsp_old), .rsp_err(rsp_err), .wb_valid(wb_valid), .wb_data(wb_data),
    .wb_mask(wb_mask));

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] model_line();
    logic [LW-1:0] r;
    for (int k = 0; k < LB; k++) r[k*8 +: 8] = mb[k];
    return r;
  endfunction

  // One atomic operation with expected values from the byte model.
  task automatic run_op(input bit op, input int sz, input int off,
                        input logic [63:0] nv, input logic [63:0] cv, input string req);
    bit legal, wr;
    logic [63:0] eold;
    logic [LB-1:0] emask;
    legal = (sz == 4 || sz == 8) && (off % ((sz == 8) ? 8 : 4) == 0);
    eold = 0; emask = 0;
    if (legal) for (int i = 0; i < sz; i++) eold[i*8 +: 8] = mb[off+i];
    wr = legal && (op == 0 || ((sz == 8) ? (cv == eold) : (cv[31:0] == eold[31:0])));
    if (wr) for (int i = 0; i < sz; i++) begin
      mb[off+i] = nv[i*8 +: 8];
      emask[off+i] = 1'b1;
    end
    @(negedge clk);
    req_valid = 1; req_op = op; req_size = 4'(sz); req_off = 5'(off);
    req_new = nv; req_cmp = cv;
    @(negedge clk);
    req_valid = 0;
    chk(busy === 1'b1, {req, " R3 busy"}, LW'(busy), 1);
    @(negedge clk);
    chk(rsp_valid === 1'b1, {req, " R3 rsp_valid"}, LW'(rsp_valid), 1);
    chk(rsp_old === eold, {req, " old"}, LW'(rsp_old), LW'(eold));
    chk(rsp_err === !legal, {req, " err"}, LW'(rsp_err), LW'(!legal));
    chk(wb_valid === wr, {req, " R9 wb_valid"}, LW'(wb_valid), LW'(wr));
    if (wr) begin
      chk(wb_data === model_line(), {req, " R9 wb_data"}, wb_data, model_line());
      chk(wb_mask === emask, {req, " R9 wb_mask"}, LW'(wb_mask), LW'(emask));
    end
  endtask

  task automatic do_fill(input logic [LW-1:0] d);
    @(negedge clk);
    fill_valid = 1; fill_data = d;
    @(negedge clk);
    fill_valid = 0;
    for (int k = 0; k < LB; k++) mb[k] = d[k*8 +: 8];
  endtask

  // Reads 8 bytes without changing them: gated exchange with a mismatching compare.
  task automatic peek8(input int off, input string req);
    logic [63:0] e;
    for (int i = 0; i < 8; i++) e[i*8 +: 8] = mb[off+i];
    run_op(1, 8, off, 64'h0, ~e, req);
  endtask

  task automatic t_reset;
    chk(busy === 0 && rsp_valid === 0 && wb_valid === 0, "R1 idle outputs",
        LW'({busy, rsp_valid, wb_valid}), 0);
    for (int k = 0; k < LB; k++) mb[k] = 8'h00;
    peek8(0, "R1 zero line lo");
    peek8(24, "R1 zero line hi");
  endtask

  task automatic t_fill;
    logic [LW-1:0] d;
    for (int k = 0; k < LB; k++) d[k*8 +: 8] = 8'(k * 7 + 3);
    do_fill(d);
    peek8(8, "R2 fill readback");
  endtask

  task automatic t_xchg;
    run_op(0, 8, 16, 64'h1122334455667788, 64'h0, "R4 xchg8");
    run_op(0, 4, 4, 64'hFFFF0000CAFEBABE, 64'h0, "R4 xchg4 R10");
    run_op(0, 8, 24, 64'hA5A5_5A5A_0F0F_F0F0, 64'h0, "R4 xchg8 last slot");
    peek8(0, "R4 neighbour intact");
  endtask

  task automatic t_cx64;
    logic [63:0] cur;
    for (int i = 0; i < 8; i++) cur[i*8 +: 8] = mb[16+i];
    run_op(1, 8, 16, 64'hDEADBEEF00C0FFEE, cur, "R5 cx8 hit");
    run_op(1, 8, 16, 64'h0123456789ABCDEF, cur, "R5 cx8 miss");
  endtask

  task automatic t_cx32;
    logic [63:0] cur;
    for (int i = 0; i < 4; i++) cur[i*8 +: 8] = mb[12+i];
    cur[63:32] = 32'h9999_1111;
    run_op(1, 4, 12, 64'h7777_7777_1357_2468, cur, "R6 cx4 upper ignored");
    run_op(1, 4, 12, 64'h0, {32'h0, ~cur[31:0]}, "R6 cx4 miss R10");
  endtask

  task automatic t_bad;
    run_op(0, 0, 0, 64'h1, 64'h0, "R7 size0");
    run_op(1, 5, 8, 64'h1, 64'h0, "R7 size5");
    run_op(0, 8, 4, 64'h1, 64'h0, "R8 off4 size8");
    run_op(1, 4, 6, 64'h1, 64'h0, "R8 off6 size4");
    peek8(0, "R7 R8 line untouched");
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    req_valid = 1; req_op = 0; req_size = 4'd8; req_off = 5'd0;
    req_new = 64'hABCD_EF01_2345_6789;
    for (int i = 0; i < 8; i++) mb[i] = req_new[i*8 +: 8];
    @(negedge clk);
    // busy now: present a second request and a fill; both must be dropped
    req_off = 5'd8; req_new = 64'hFEED_FEED_FEED_FEED;
    fill_valid = 1; fill_data = {LW{1'b1}};
    @(negedge clk);
    req_valid = 0; fill_valid = 0;
    chk(rsp_valid === 1 && wb_valid === 1, "R3 first op responds",
        LW'({rsp_valid, wb_valid}), 3);
    @(negedge clk);
    chk(rsp_valid === 0 && busy === 0, "R3 busy request ignored",
        LW'({rsp_valid, busy}), 0);
    peek8(8, "R3 R2 line unchanged after busy stimulus");
    peek8(0, "R3 first op stored");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill();
    t_xchg();
    t_cx64();
    t_cx32();
    t_bad();
    t_busy_ignore();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule